// File: doc/BRIEF.md
# Transmit Mailbox Code Sequencer

This block holds the four-bit status code, remote-request bit and 11-bit identifier of eight transmit mailboxes. Software loads a mailbox through a write port. The block reports to an external arbiter which mailboxes are ready to send. It moves each code forward when the arbiter signals that a frame went out, or when a remote-request frame arrives whose identifier equals that of a mailbox waiting in standby.

Three kinds of transmission are supported:
- a one-shot data frame;
- a one-shot remote frame, after which the mailbox becomes an empty receiver and keeps its identifier;
- an answer loop, in which a standby mailbox (1010) is armed (1110) by a matching remote request, sends once, and then returns to standby.

When the abort enable is high, a pending mailbox can be withdrawn to code 1001. An abort aimed at the mailbox the arbiter is currently sending is ignored. A transmit-done that names a mailbox which was not pending sets a sticky error flag.

Both data inputs use valid/ready handshakes:
- A write is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` drops only in a cycle where `done_valid` names the same mailbox as `wr_idx`. The write must then be held until it is accepted.
- `rr_ready` is always high, so a remote request is consumed in the cycle it is presented.

All other pins are plain control and status.

Top module: `txmb_seq`

## Requirements
- R1: After reset every mailbox holds code 1000 with remote-request bit 0 and identifier 0, `elig` is 0 and `err_sticky` is 0.
- R2: Bit i of `elig` is 1 exactly when mailbox i holds code 1100 or 1110, and it reflects the registered code.
- R3: A transmit-done on a mailbox holding 1100 with remote-request bit 0 sets its code to 1000 on the next cycle.
- R4: A transmit-done on a mailbox holding 1100 with remote-request bit 1 sets its code to 0100 on the next cycle and keeps its identifier and remote-request bit.
- R5: A remote request whose identifier equals that of a mailbox holding 1010 with remote-request bit 0 sets that mailbox to 1110 on the next cycle. Every such mailbox is affected. Mailboxes with another identifier, another code or remote-request bit 1 are unchanged.
- R6: A transmit-done on a mailbox holding 1110 returns it to 1010. A write of 1110 makes the mailbox eligible on the next cycle.
- R7: With `abort_en` high, an abort on a mailbox whose code has bit 3 set and which is not the one flagged by `tx_active`/`tx_active_idx` sets its code to 1001 on the next cycle. Such a mailbox is not eligible.
- R8: A transmit-done on a mailbox not holding 1100 or 1110 leaves its code unchanged and sets `err_sticky`, which stays 1 until reset.
- R9: An abort on the mailbox being sent is ignored, and its later transmit-done applies the normal post-success code.
- R10: `rd_busy` is 1 only when `abort_en` is high and `tx_active` flags the mailbox selected by `rd_idx`. It reads 0 whenever `abort_en` is low.
- R11: With `abort_en` low, abort requests have no effect, and a write of code 1001 stores 1000.
- R12: `wr_ready` is 0 exactly when `done_valid` is high and `done_idx` equals `wr_idx`. A write offered in that cycle is not taken, and the transmit-done result stands.
- R13: An accepted write stores its code, remote-request bit and identifier, and these are readable on `rd_code`/`rd_rtr`/`rd_id` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_en | input | 1 | Enables the abort feature and the busy indication |
| wr_valid | input | 1 | Software write offered |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_idx | input | 3 | Mailbox addressed by the write |
| wr_code | input | 4 | Code to store |
| wr_rtr | input | 1 | Remote-request bit to store |
| wr_id | input | 11 | Identifier to store |
| done_valid | input | 1 | Transmit-done pulse |
| done_idx | input | 3 | Mailbox whose frame was sent |
| abort_req | input | 1 | Abort request pulse |
| abort_idx | input | 3 | Mailbox to abort |
| tx_active | input | 1 | Arbiter is sending a mailbox |
| tx_active_idx | input | 3 | Mailbox being sent |
| rr_valid | input | 1 | Incoming remote request offered |
| rr_ready | output | 1 | Remote request accepted (always 1) |
| rr_id | input | 11 | Identifier of the remote request |
| rd_idx | input | 3 | Mailbox selected for reading |
| rd_code | output | 4 | Code of the selected mailbox |
| rd_rtr | output | 1 | Remote-request bit of the selected mailbox |
| rd_id | output | 11 | Identifier of the selected mailbox |
| rd_busy | output | 1 | Selected mailbox is being sent (only with abort_en) |
| elig | output | 8 | Per-mailbox eligibility for arbitration |
| err_sticky | output | 1 | A transmit-done named a non-pending mailbox |

## Verification
The hardest situation to reach is a single cycle in which several events land on the same mailbox: a write racing a transmit-done, or an abort racing an active transmission. The bench first parks a mailbox in a pending code and holds `tx_active` on it. It then presents the abort, or the write together with the transmit-done, in the same cycle. Finally it reads the code back through `rd_idx` to see which event won. A remote request that matches one standby mailbox while another with an equal identifier has its remote-request bit set is also built deliberately. This shows that only the first mailbox is armed.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] CD_INACT   = 4'b1000;
  localparam logic [CODE_W-1:0] CD_ABORT   = 4'b1001;
  localparam logic [CODE_W-1:0] CD_ONCE    = 4'b1100;
  localparam logic [CODE_W-1:0] CD_STBY    = 4'b1010;
  localparam logic [CODE_W-1:0] CD_ANSWER  = 4'b1110;
  localparam logic [CODE_W-1:0] CD_RXEMPTY = 4'b0100;

  function automatic logic is_pending(input logic [CODE_W-1:0] c);
    return (c == CD_ONCE) || (c == CD_ANSWER);
  endfunction
endpackage

// File: rtl/txmb_slot.sv
module txmb_slot
  import txmb_pkg::*;
#(
  parameter int unsigned ID_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_en,
  input  logic              done_hit,
  input  logic              wr_hit,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_rtr,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              abort_hit,
  input  logic              active_hit,
  input  logic              rr_valid,
  input  logic [ID_W-1:0]   rr_id,
  output logic [CODE_W-1:0] code_o,
  output logic              rtr_o,
  output logic [ID_W-1:0]   id_o,
  output logic              elig_o,
  output logic              done_bad_o
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              rtr_q, rtr_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic              rr_match, abort_ok;

  assign rr_match = rr_valid && (code_q == CD_STBY) && !rtr_q && (id_q == rr_id);
  assign abort_ok = abort_en && abort_hit && !active_hit && code_q[3];

  always_comb begin
    code_d     = code_q;
    rtr_d      = rtr_q;
    id_d       = id_q;
    done_bad_o = 1'b0;
    if (done_hit) begin
      unique case (code_q)
        CD_ONCE:   code_d = rtr_q ? CD_RXEMPTY : CD_INACT;
        CD_ANSWER: code_d = CD_STBY;
        default:   done_bad_o = 1'b1;
      endcase
    end else if (wr_hit) begin
      code_d = ((wr_code == CD_ABORT) && !abort_en) ? CD_INACT : wr_code;
      rtr_d  = wr_rtr;
      id_d   = wr_id;
    end else if (abort_ok) begin
      code_d = CD_ABORT;
    end else if (rr_match) begin
      code_d = CD_ANSWER;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= CD_INACT;
      rtr_q  <= 1'b0;
      id_q   <= '0;
    end else begin
      code_q <= code_d;
      rtr_q  <= rtr_d;
      id_q   <= id_d;
    end
  end

  assign code_o = code_q;
  assign rtr_o  = rtr_q;
  assign id_o   = id_q;
  assign elig_o = is_pending(code_q);

  assert_once_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_hit && code_q == CD_ONCE && !rtr_q) |=> (code_o == CD_INACT));
  assert_once_remote_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_hit && code_q == CD_ONCE && rtr_q) |=> (code_o == CD_RXEMPTY && $stable(id_o)));
  assert_answer_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_hit && code_q == CD_ANSWER) |=> (code_o == CD_STBY));
  assert_rr_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_match && !done_hit && !wr_hit && !abort_hit) |=> elig_o);
  assert_abort_ineligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ok && !done_hit && !wr_hit) |=> (!elig_o && code_o == CD_ABORT));
  assert_active_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_hit && active_hit && !done_hit && !wr_hit && code_q == CD_ONCE) |=> (code_o == CD_ONCE));
endmodule

// File: rtl/txmb_rdmux.sv
module txmb_rdmux
  import txmb_pkg::*;
#(
  parameter int unsigned N_MB = 8,
  parameter int unsigned ID_W = 11,
  localparam int unsigned IDX_W = $clog2(N_MB)
) (
  input  logic [N_MB-1:0][CODE_W-1:0] codes,
  input  logic [N_MB-1:0]             rtrs,
  input  logic [N_MB-1:0][ID_W-1:0]   ids,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic                        abort_en,
  input  logic                        tx_active,
  input  logic [IDX_W-1:0]            tx_active_idx,
  output logic [CODE_W-1:0]           rd_code,
  output logic                        rd_rtr,
  output logic [ID_W-1:0]             rd_id,
  output logic                        rd_busy
);
  assign rd_code = codes[rd_idx];
  assign rd_rtr  = rtrs[rd_idx];
  assign rd_id   = ids[rd_idx];
  assign rd_busy = abort_en && tx_active && (tx_active_idx == rd_idx);

  always_comb begin
    assert_busy_gated_R10: assert (abort_en || !rd_busy);
  end
endmodule

// File: rtl/txmb_seq.sv
module txmb_seq
  import txmb_pkg::*;
#(
  parameter int unsigned N_MB = 8,
  parameter int unsigned ID_W = 11,
  localparam int unsigned IDX_W = $clog2(N_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_rtr,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic              abort_req,
  input  logic [IDX_W-1:0]  abort_idx,
  input  logic              tx_active,
  input  logic [IDX_W-1:0]  tx_active_idx,
  input  logic              rr_valid,
  output logic              rr_ready,
  input  logic [ID_W-1:0]   rr_id,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_code,
  output logic              rd_rtr,
  output logic [ID_W-1:0]   rd_id,
  output logic              rd_busy,
  output logic [N_MB-1:0]   elig,
  output logic              err_sticky
);
  logic [N_MB-1:0][CODE_W-1:0] codes;
  logic [N_MB-1:0]             rtrs;
  logic [N_MB-1:0][ID_W-1:0]   ids;
  logic [N_MB-1:0]             bad;
  logic                        wr_take;
  logic                        err_q;

  assign wr_ready = !(done_valid && (done_idx == wr_idx));
  assign wr_take  = wr_valid && wr_ready;
  assign rr_ready = 1'b1;

  for (genvar g = 0; g < N_MB; g++) begin : g_slot
    txmb_slot #(.ID_W(ID_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort_en   (abort_en),
      .done_hit   (done_valid && (done_idx == IDX_W'(g))),
      .wr_hit     (wr_take && (wr_idx == IDX_W'(g))),
      .wr_code    (wr_code),
      .wr_rtr     (wr_rtr),
      .wr_id      (wr_id),
      .abort_hit  (abort_req && (abort_idx == IDX_W'(g))),
      .active_hit (tx_active && (tx_active_idx == IDX_W'(g))),
      .rr_valid   (rr_valid),
      .rr_id      (rr_id),
      .code_o     (codes[g]),
      .rtr_o      (rtrs[g]),
      .id_o       (ids[g]),
      .elig_o     (elig[g]),
      .done_bad_o (bad[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (|bad) err_q <= 1'b1;
  end
  assign err_sticky = err_q;

  txmb_rdmux #(.N_MB(N_MB), .ID_W(ID_W)) u_rd (
    .codes         (codes),
    .rtrs          (rtrs),
    .ids           (ids),
    .rd_idx        (rd_idx),
    .abort_en      (abort_en),
    .tx_active     (tx_active),
    .tx_active_idx (tx_active_idx),
    .rd_code       (rd_code),
    .rd_rtr        (rd_rtr),
    .rd_id         (rd_id),
    .rd_busy       (rd_busy)
  );

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !elig[done_idx]) |=> err_sticky);
  assert_wr_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> (done_valid && done_idx == wr_idx));
  assert_elig_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (elig[rd_idx] == (rd_code == CD_ONCE || rd_code == CD_ANSWER)));
endmodule

// File: tb/txmb_seq_tb.sv
module txmb_seq_tb;
  localparam int CLK_P = 10;
  localparam int NV = 14;
  // {op[2], idx[3], code[4], rtr, id[11], exp_code[4], exp_elig[8]}; op 0=wr 1=done 2=rr 3=abort
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 3'd0, 4'b1100, 1'b0, 11'h100, 4'b1100, 8'h01},
    {2'd1, 3'd0, 4'b0000, 1'b0, 11'h000, 4'b1000, 8'h00},
    {2'd0, 3'd1, 4'b1100, 1'b1, 11'h055, 4'b1100, 8'h02},
    {2'd1, 3'd1, 4'b0000, 1'b0, 11'h000, 4'b0100, 8'h00},
    {2'd0, 3'd2, 4'b1010, 1'b0, 11'h2AA, 4'b1010, 8'h00},
    {2'd2, 3'd2, 4'b0000, 1'b0, 11'h2AB, 4'b1010, 8'h00},
    {2'd2, 3'd2, 4'b0000, 1'b0, 11'h2AA, 4'b1110, 8'h04},
    {2'd1, 3'd2, 4'b0000, 1'b0, 11'h000, 4'b1010, 8'h00},
    {2'd0, 3'd3, 4'b1110, 1'b0, 11'h011, 4'b1110, 8'h08},
    {2'd3, 3'd3, 4'b0000, 1'b0, 11'h000, 4'b1001, 8'h00},
    {2'd1, 3'd3, 4'b0000, 1'b0, 11'h000, 4'b1001, 8'h00},
    {2'd0, 3'd4, 4'b1010, 1'b1, 11'h2AA, 4'b1010, 8'h00},
    {2'd2, 3'd4, 4'b0000, 1'b0, 11'h2AA, 4'b1010, 8'h04},
    {2'd1, 3'd2, 4'b0000, 1'b0, 11'h000, 4'b1010, 8'h00}
  };

  logic clk = 0, rst_n = 0, abort_en = 0;
  logic wr_valid = 0, wr_rtr = 0;
  logic [2:0] wr_idx = 0, done_idx = 0, abort_idx = 0, tx_active_idx = 0, rd_idx = 0;
  logic [3:0] wr_code = 0;
  logic [10:0] wr_id = 0, rr_id = 0;
  logic done_valid = 0, abort_req = 0, tx_active = 0, rr_valid = 0;
  logic wr_ready, rr_ready, rd_rtr, rd_busy, err_sticky;
  logic [3:0] rd_code;
  logic [10:0] rd_id;
  logic [7:0] elig;
  int errors = 0, checks = 0;
  bit done_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  txmb_seq u_dut (
    .clk(clk), .rst_n(rst_n), .abort_en(abort_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_code(wr_code),
    .wr_rtr(wr_rtr), .wr_id(wr_id), .done_valid(done_valid), .done_idx(done_idx),
    .abort_req(abort_req), .abort_idx(abort_idx), .tx_active(tx_active),
    .tx_active_idx(tx_active_idx), .rr_valid(rr_valid), .rr_ready(rr_ready),
    .rr_id(rr_id), .rd_idx(rd_idx), .rd_code(rd_code), .rd_rtr(rd_rtr),
    .rd_id(rd_id), .rd_busy(rd_busy), .elig(elig), .err_sticky(err_sticky)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_pulses();
    wr_valid = 0; done_valid = 0; abort_req = 0; rr_valid = 0;
  endtask

  task automatic do_write(input logic [2:0] i, input logic [3:0] c, input logic r, input logic [10:0] id);
    @(negedge clk);
    wr_valid = 1; wr_idx = i; wr_code = c; wr_rtr = r; wr_id = id;
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic do_done(input logic [2:0] i);
    @(negedge clk);
    done_valid = 1; done_idx = i;
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic do_abort(input logic [2:0] i);
    @(negedge clk);
    abort_req = 1; abort_idx = i;
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic peek(input logic [2:0] i);
    rd_idx = i;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      peek(3'(i));
      chk(rd_code == 4'b1000 && rd_rtr == 0 && rd_id == 0, "R1", rd_code, 4'b1000);
    end
    chk(elig == 0, "R1", elig, 0);
    chk(err_sticky == 0, "R1", err_sticky, 0);
    chk(wr_ready == 1 && rr_ready == 1, "R12", wr_ready, 1);

    // Table walk (R2..R8, R13)
    abort_en = 1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      case (VEC[v][32:31])
        2'd0: begin wr_valid = 1; wr_idx = VEC[v][30:28]; wr_code = VEC[v][27:24];
                    wr_rtr = VEC[v][23]; wr_id = VEC[v][22:12]; end
        2'd1: begin done_valid = 1; done_idx = VEC[v][30:28]; end
        2'd2: begin rr_valid = 1; rr_id = VEC[v][22:12]; end
        default: begin abort_req = 1; abort_idx = VEC[v][30:28]; end
      endcase
      @(negedge clk);
      clear_pulses();
      peek(VEC[v][30:28]);
      chk(rd_code == VEC[v][11:8], "R2/R3/R4/R5/R6/R7/R8/R13 code", rd_code, VEC[v][11:8]);
      chk(elig == VEC[v][7:0], "R2 elig", elig, VEC[v][7:0]);
    end

    // R4 identifier kept; R13 fields readable
    peek(3'd1);
    chk(rd_id == 11'h055 && rd_rtr == 1, "R4 id kept", rd_id, 11'h055);
    peek(3'd4);
    chk(rd_id == 11'h2AA && rd_rtr == 1, "R13 fields", rd_id, 11'h2AA);
    // R8 sticky error
    chk(err_sticky == 1, "R8 err set", err_sticky, 1);
    do_write(3'd0, 4'b1100, 1'b0, 11'h7);
    chk(err_sticky == 1, "R8 err stays", err_sticky, 1);

    // R9 abort during active transmission; R10 busy
    do_write(3'd5, 4'b1100, 1'b0, 11'h123);
    @(negedge clk);
    tx_active = 1; tx_active_idx = 3'd5;
    peek(3'd5);
    chk(rd_busy == 1, "R10 busy set", rd_busy, 1);
    peek(3'd4);
    chk(rd_busy == 0, "R10 busy other", rd_busy, 0);
    do_abort(3'd5);
    peek(3'd5);
    chk(rd_code == 4'b1100, "R9 abort ignored", rd_code, 4'b1100);
    abort_en = 0;
    #1;
    chk(rd_busy == 0, "R10 busy gated", rd_busy, 0);
    abort_en = 1;
    do_done(3'd5);
    tx_active = 0;
    peek(3'd5);
    chk(rd_code == 4'b1000, "R9 post-success", rd_code, 4'b1000);

    // R11 abort disabled
    abort_en = 0;
    do_write(3'd6, 4'b1100, 1'b0, 11'h0);
    do_abort(3'd6);
    peek(3'd6);
    chk(rd_code == 4'b1100, "R11 abort ignored", rd_code, 4'b1100);
    do_write(3'd6, 4'b1001, 1'b0, 11'h0);
    peek(3'd6);
    chk(rd_code == 4'b1000, "R11 abort write", rd_code, 4'b1000);
    abort_en = 1;

    // R12 write collides with transmit-done
    do_write(3'd7, 4'b1100, 1'b0, 11'h3);
    @(negedge clk);
    wr_valid = 1; wr_idx = 3'd7; wr_code = 4'b1010; wr_rtr = 0; wr_id = 11'h3;
    done_valid = 1; done_idx = 3'd7;
    #1;
    chk(wr_ready == 0, "R12 ready low", wr_ready, 0);
    @(negedge clk);
    clear_pulses();
    peek(3'd7);
    chk(rd_code == 4'b1000, "R12 done wins", rd_code, 4'b1000);
    // R6 CPU write of 1110 eligible directly
    do_write(3'd7, 4'b1110, 1'b0, 11'h3);
    #1;
    chk(elig[7] == 1, "R6 write arms", elig[7], 1);

    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule